// File: doc/BRIEF.md
# Key-Protected Countdown Watchdog

This block is a hardware watchdog that guards a processor against a hang. A slow tick is divided down from the system clock by a power-of-two prescaler, and each tick decrements an 8-bit down-counter. Software arms the watchdog and keeps it alive by writing a control word. The word carries a start value, a start or stop command, and a 7-bit key. One tick before the count runs out, the block sends a single-cycle non-maskable interrupt request, so that a handler can save state. When the count reaches zero, the block raises a chip-reset request and holds it.

A control word counts only when its key is the bitwise inverse of the key in the last accepted word. A runaway program that keeps rewriting one value therefore cannot keep the watchdog alive, and it cannot stop it either. The block drops every rejected word without a trace.

Top module: `kwdog_top`

## Requirements
- R1: After a synchronous active-low reset the watchdog is stopped, `nmi_req` and `chip_rst` are low, and the stored key is 7'h00, so the first acceptable key is 7'h7F.
- R2: A write (`ctl_wr` high at a clock edge) is accepted only when `ctl_key` equals the bitwise inverse of the stored key. The accepted key then becomes the stored key.
- R3: A rejected write leaves the count, the run state and the stored key unchanged, including a write that repeats the last accepted key.
- R4: While running, the counter decrements once every 2^PRESCALE_W clock cycles. An accepted start clears the prescaler, so the first decrement lands 2^PRESCALE_W edges after the accepting edge.
- R5: `nmi_req` is a one-cycle pulse, issued in the cycle after the count steps from 2 to 1, that is (N-1)*2^PRESCALE_W edges after a start with value N >= 2.
- R6: When the count reaches 0 (N*2^PRESCALE_W edges after a start with N >= 1), `chip_rst` rises and stays high until `rst_n` is asserted.
- R7: An accepted start (`ctl_cmd` = 1) while running reloads the count and restarts the prescaler (kick).
- R8: An accepted stop (`ctl_cmd` = 0) freezes the count. No interrupt and no reset follow while the watchdog is stopped.
- R9: A start value of 1 bites on the first tick with no interrupt pulse. A start value of 0 also bites on the first tick.
- R10: Once `chip_rst` is high, all writes are ignored, including a correctly keyed stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_count | input | CNT_W | Start value loaded on an accepted start |
| ctl_cmd | input | 1 | 1 = start/kick, 0 = stop |
| ctl_key | input | KEY_W | Key, must be the inverse of the last accepted key |
| nmi_req | output | 1 | One-cycle early-warning interrupt pulse |
| chip_rst | output | 1 | Sticky chip-reset request |

## Verification
The bench sweeps start values from 0 through 255 with a 4-cycle tick and checks, edge by edge, where the interrupt pulse and the reset fall. A prescaler that is not cleared on a start, or that is off by one, shifts both events. The bench also presents a stale key, a repeated key and a wrong-key kick or stop. A design that accepts any of these would reload, stop or re-key, and the moment of the bite would move. Kicks, stops and a restart after a stop show whether the key sequence keeps alternating. Writes after a bite show whether the reset stays held.

// File: rtl/kwdog_pkg.sv
// Package: shared command encoding for the key-protected watchdog.
// Assumes a single command bit in the control word.
package kwdog_pkg;
    typedef enum logic {
        WD_CMD_HALT = 1'b0,
        WD_CMD_ARM  = 1'b1
    } wd_cmd_e;
endpackage

// File: rtl/kwdog_keycheck.sv
// Module: key gate. Holds the last accepted key and accepts a write only when
// the presented key is its bitwise inverse. Assumes writes are single-cycle
// strobes and that a bitten watchdog accepts nothing until reset.
module kwdog_keycheck #(
    parameter int KEY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             bitten,
    output logic             accept
);
    logic [KEY_W-1:0] key_q;

    // Acceptance: strobe present, not bitten, key is inverse of stored key.
    assign accept = wr_en && !bitten && (wr_key == ~key_q);

    // Key register: reset to zero, replaced only by an accepted key.
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= '0;
        else if (accept) key_q <= wr_key;
    end

    assert_key_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (key_q == ~$past(key_q)));
    assert_key_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(key_q));
endmodule

// File: rtl/kwdog_prescaler.sv
// Module: tick divider. Emits a one-cycle tick every 2^PRESCALE_W cycles while
// running. Assumes a restart clears the phase so the first tick follows
// exactly 2^PRESCALE_W edges after the restart edge.
module kwdog_prescaler #(
    parameter int PRESCALE_W = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam logic [PRESCALE_W-1:0] PHASE_TOP = '1;

    logic [PRESCALE_W-1:0] phase_q;

    // Tick on the last phase of each period, only while running.
    assign tick = run && (phase_q == PHASE_TOP);

    // Phase counter: cleared by reset and restart, advances while running.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (restart) phase_q <= '0;
        else if (run)     phase_q <= phase_q + 1'b1;
    end

    assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/kwdog_counter.sv
// Module: countdown core. Loads a start value, decrements on each tick,
// pulses the early-warning interrupt on the step 2 -> 1 and latches the bite
// when the count is exhausted. Assumes load and halt are already key-checked
// and never both high.
module kwdog_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             halt,
    input  logic             tick,
    output logic             running,
    output logic             nmi_pulse,
    output logic             bitten
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

    logic [CNT_W-1:0] count_q;
    logic             run_q;
    logic             nmi_q;
    logic             bite_q;

    assign running   = run_q;
    assign nmi_pulse = nmi_q;
    assign bitten    = bite_q;

    // Count and run state: load beats halt beats tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else if (load) begin
            count_q <= load_val;
            run_q   <= 1'b1;
        end else if (halt) begin
            run_q   <= 1'b0;
        end else if (tick) begin
            if (count_q <= CNT_ONE) begin
                count_q <= '0;
                run_q   <= 1'b0;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    // Early-warning pulse: one cycle after a tick moves the count from 2 to 1.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= tick && !load && !halt && (count_q == CNT_TWO);
    end

    // Bite latch: set when a tick finds the count exhausted, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          bite_q <= 1'b0;
        else if (tick && !load && !halt && count_q <= CNT_ONE) bite_q <= 1'b1;
    end

    assert_nmi_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_q |=> !nmi_q);
    assert_nmi_at_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_q |-> (count_q == CNT_ONE) && run_q);
    assert_bite_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bite_q |=> bite_q);
    assert_bite_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bite_q) |-> (count_q == '0) && !run_q);
    assert_kick_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(load_val)) && run_q);
    assert_frozen_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load) |=> $stable(count_q));
endmodule

// File: rtl/kwdog_top.sv
// Module: key-protected watchdog top. Decodes the control word through the key
// gate, drives the prescaler and the countdown core, and exposes the
// interrupt pulse and sticky reset request. Assumes one write per strobe.
module kwdog_top #(
    parameter int CNT_W      = 8,
    parameter int KEY_W      = 7,
    parameter int PRESCALE_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CNT_W-1:0] ctl_count,
    input  logic             ctl_cmd,
    input  logic [KEY_W-1:0] ctl_key,
    output logic             nmi_req,
    output logic             chip_rst
);
    import kwdog_pkg::*;

    logic accept;
    logic arm;
    logic halt;
    logic tick;
    logic running;
    logic bitten;

    // Command decode of an accepted write.
    assign arm  = accept && (wd_cmd_e'(ctl_cmd) == WD_CMD_ARM);
    assign halt = accept && (wd_cmd_e'(ctl_cmd) == WD_CMD_HALT);

    kwdog_keycheck #(.KEY_W(KEY_W)) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctl_wr),
        .wr_key (ctl_key),
        .bitten (bitten),
        .accept (accept)
    );

    kwdog_prescaler #(.PRESCALE_W(PRESCALE_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (arm),
        .tick    (tick)
    );

    kwdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (arm),
        .load_val  (ctl_count),
        .halt      (halt),
        .tick      (tick),
        .running   (running),
        .nmi_pulse (nmi_req),
        .bitten    (bitten)
    );

    assign chip_rst = bitten;

    assert_no_accept_after_bite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |-> !accept);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> !nmi_req && !chip_rst);
endmodule

// File: tb/kwdog_top_bench.sv
`timescale 1ns/1ps
module kwdog_top_bench;
    localparam int CW = 8;
    localparam int KW = 7;
    localparam int PW = 2;
    localparam int T  = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [CW-1:0] ctl_count = '0;
    logic          ctl_cmd = 1'b0;
    logic [KW-1:0] ctl_key = '0;
    logic          nmi_req;
    logic          chip_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [KW-1:0] exp_key;

    always #10 clk = ~clk;

    kwdog_top #(.CNT_W(CW), .KEY_W(KW), .PRESCALE_W(PW)) u_kwdog_top (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_count(ctl_count),
        .ctl_cmd(ctl_cmd), .ctl_key(ctl_key), .nmi_req(nmi_req), .chip_rst(chip_rst)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reset for three cycles; outputs must be low (R1). Ends at a negedge.
    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        ctl_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk(!nmi_req, "R1 nmi low in reset", int'(nmi_req), 0);
        chk(!chip_rst, "R1 chip_rst low in reset", int'(chip_rst), 0);
        rst_n   = 1'b1;
        exp_key = '0;
        @(negedge clk);
    endtask

    // One write strobe, from a negedge to the negedge after its edge.
    task automatic do_write(input int cnt, input bit cmd, input logic [KW-1:0] key);
        ctl_wr    = 1'b1;
        ctl_count = CW'(cnt);
        ctl_cmd   = cmd;
        ctl_key   = key;
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic good_write(input int cnt, input bit cmd);
        exp_key = ~exp_key;
        do_write(cnt, cmd, exp_key);
    endtask

    // Check outputs for edges t0..t1 after a start of value n (t = edges since start edge).
    task automatic observe(input int n, input int t0, input int t1, input string tag);
        int bite_t;
        bite_t = ((n == 0) ? 1 : n) * T;
        for (int t = t0; t <= t1; t++) begin
            bit ne;
            bit re;
            if (t > t0) begin
                @(posedge clk);
                @(negedge clk);
            end
            ne = (n >= 2) && (t == (n - 1) * T);
            re = (t >= bite_t);
            chk(nmi_req == ne, $sformatf("%s nmi n=%0d t=%0d", tag, n, t), int'(nmi_req), int'(ne));
            chk(chip_rst == re, $sformatf("%s chip_rst n=%0d t=%0d", tag, n, t), int'(chip_rst), int'(re));
        end
    endtask

    // Quiet window: neither output may rise.
    task automatic quiet(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk(!nmi_req && !chip_rst, tag, int'({nmi_req, chip_rst}), 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int sweep [10] = '{0, 1, 2, 3, 4, 5, 7, 16, 100, 255};

        // R1: reset state and no activity while stopped.
        do_reset();
        quiet(20, "R1 stopped after reset");

        // R3: wrong key (0x00 repeats the reset key) and other stale keys do not start.
        do_write(2, 1'b1, 7'h00);
        quiet(16, "R3 stale key ignored");
        do_write(2, 1'b1, 7'h55);
        quiet(16, "R3 wrong key ignored");

        // R2/R4/R5/R6/R9: sweep of start values, first valid key 0x7F.
        foreach (sweep[i]) begin
            do_reset();
            good_write(sweep[i], 1'b1);
            chk(exp_key == 7'h7F, "R2 first key", int'(exp_key), 127);
            observe(sweep[i], 0, ((sweep[i] == 0) ? 1 : sweep[i]) * T + 6, "R4 R5 R6 R9 sweep");
        end

        // R10: after the bite a correctly keyed stop and start are ignored.
        good_write(3, 1'b0);
        quiet(0, "R10");
        chk(chip_rst, "R10 held after keyed stop", int'(chip_rst), 1);
        good_write(10, 1'b1);
        repeat (50) @(negedge clk);
        chk(chip_rst && !nmi_req, "R10 held after keyed start", int'({chip_rst, nmi_req}), 2);

        // R7: a keyed kick reloads the count and restarts the prescaler.
        do_reset();
        good_write(4, 1'b1);
        observe(4, 0, 9, "R7 before kick");
        good_write(4, 1'b1);
        observe(4, 0, 20, "R7 after kick");

        // R3: a kick with the repeated key is ignored; the bite keeps its time.
        do_reset();
        good_write(4, 1'b1);
        observe(4, 0, 8, "R3 before bad kick");
        do_write(50, 1'b1, exp_key);
        observe(4, 9, 20, "R3 bad kick");

        // R8: keyed stop freezes; keyed restart afterwards works (key keeps alternating).
        do_reset();
        good_write(3, 1'b1);
        observe(3, 0, 5, "R8 before stop");
        good_write(0, 1'b0);
        quiet(60, "R8 stopped");
        good_write(2, 1'b1);
        observe(2, 0, 12, "R8 restart");

        // R3: a stop with the wrong key is ignored.
        do_reset();
        good_write(3, 1'b1);
        observe(3, 0, 4, "R3 before bad stop");
        do_write(0, 1'b0, ~(~exp_key) ^ 7'h01);
        observe(3, 5, 16, "R3 bad stop");

        // R6: external reset clears the held chip reset.
        do_reset();
        chk(!chip_rst, "R6 cleared by rst_n", int'(chip_rst), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule